// File: doc/BRIEF.md
# Subband Transpose and Rearrange Unit

This unit joins the row pass, the column pass and the output of a two-dimensional lifting wavelet engine. Its transpose half takes one high-pass (H) and one low-pass (L) coefficient per lane from each parallel row unit, beat by beat. It collects two consecutive row beats and gives each column unit first the two H values, then the two L values, on consecutive cycles.

Its rearrange half takes the column units' output pairs. These arrive as a (HL,HH) pair followed by a (LL,LH) pair, and the sequence repeats. The unit keeps the first pair in registers. When the second pair arrives it shows all four subbands at once on separate LL, LH, HL and HH ports, with one shared valid pulse. A start-of-strip flag on each side forces the pairing phase back to its start, so groups stay aligned across strips. The unit holds no frame memory and does no lifting arithmetic.

Top module: `subband_xpose_rearr`

## Requirements
- R1: After reset, `xp_vld` and `sb_vld` are 0 and every data output is 0.
- R2: On each lane, the row beat that closes a pair makes the next cycle show `xp_vld`=1 and `xp_is_l`=0, with `xp_a` holding the earlier beat's H value and `xp_b` the later beat's H value. The beat that opens a pair raises no `xp_vld`.
- R3: The cycle after an H pair shows `xp_vld`=1 and `xp_is_l`=1, with `xp_a` holding the earlier beat's L value and `xp_b` the later beat's L value.
- R4: A row beat with `row_sos`=1 always opens a new pair, and any half-collected pair is dropped.
- R5: On each lane, a column beat that opens a pair is taken as `col_x`=HL and `col_y`=HH and raises no `sb_vld`. The beat that closes the pair is taken as `col_x`=LL and `col_y`=LH. The next cycle then shows `sb_vld`=1 together with all four subbands of that group.
- R6: A column beat with `col_sos`=1 always opens a new pair, and any pending (HL,HH) pair is dropped.
- R7: While `xp_vld` is 0, `xp_a` and `xp_b` keep their values. While `sb_vld` is 0, the four subband outputs keep their values. `sb_vld` never stays high for two cycles in a row.
- R8: A pair left half-collected when reset is applied raises no valid. The first beat after reset opens a new pair.
- R9: Cycles with the beat valid at 0 neither advance the pairing phase nor change any output.
- R10: Lane i of every packed bus occupies bits [i*W +: W]. W is 15 and the lane count is 2 by default, and the lanes are processed independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| row_vld | input | 1 | Row beat valid |
| row_sos | input | 1 | Row beat opens a new strip |
| row_h | input | NPU*W | Row H coefficient per lane |
| row_l | input | NPU*W | Row L coefficient per lane |
| xp_vld | output | 1 | Column-side pair valid |
| xp_is_l | output | 1 | 0: pair is H, 1: pair is L |
| xp_a | output | NPU*W | Earlier row's coefficient per lane |
| xp_b | output | NPU*W | Later row's coefficient per lane |
| col_vld | input | 1 | Column beat valid |
| col_sos | input | 1 | Column beat opens a new strip |
| col_x | input | NPU*W | First value of a column pair (HL or LL) |
| col_y | input | NPU*W | Second value of a column pair (HH or LH) |
| sb_vld | output | 1 | All four subbands valid |
| sb_ll | output | NPU*W | LL subband per lane |
| sb_lh | output | NPU*W | LH subband per lane |
| sb_hl | output | NPU*W | HL subband per lane |
| sb_hh | output | NPU*W | HH subband per lane |

## Verification
The embedded properties take for granted that `row_vld` and `col_vld` are low while reset is held. They also assume every input is a known value from the first edge after reset. A strip flag is assumed to count only when it comes with its valid. The stimulus therefore holds every input at zero through reset, and changes inputs only on falling edges. It raises `row_sos` and `col_sos` only together with a valid beat, including the cases that break a half-collected pair.

// File: rtl/subband_xpose_rearr.sv
module subband_xpose_rearr #(
  parameter int W   = 15,
  parameter int NPU = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              row_vld,
  input  logic              row_sos,
  input  logic [NPU*W-1:0]  row_h,
  input  logic [NPU*W-1:0]  row_l,
  output logic              xp_vld,
  output logic              xp_is_l,
  output logic [NPU*W-1:0]  xp_a,
  output logic [NPU*W-1:0]  xp_b,
  input  logic              col_vld,
  input  logic              col_sos,
  input  logic [NPU*W-1:0]  col_x,
  input  logic [NPU*W-1:0]  col_y,
  output logic              sb_vld,
  output logic [NPU*W-1:0]  sb_ll,
  output logic [NPU*W-1:0]  sb_lh,
  output logic [NPU*W-1:0]  sb_hl,
  output logic [NPU*W-1:0]  sb_hh
);
  localparam int BW = NPU * W;

  logic          rph, cph, l_pend;
  logic [BW-1:0] hold_h, hold_l, lq_a, lq_b, lat_hl, lat_hh;
  logic          row_close, col_close;

  assign row_close = row_vld && !row_sos && rph;
  assign col_close = col_vld && !col_sos && cph;

  // transpose side: two row beats -> H pair, then L pair
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rph     <= 1'b0;
      l_pend  <= 1'b0;
      hold_h  <= '0;
      hold_l  <= '0;
      lq_a    <= '0;
      lq_b    <= '0;
      xp_vld  <= 1'b0;
      xp_is_l <= 1'b0;
      xp_a    <= '0;
      xp_b    <= '0;
    end else begin
      if (row_vld) begin
        rph <= !row_close;
        if (!row_close) begin
          hold_h <= row_h;
          hold_l <= row_l;
        end
      end
      if (row_close) begin
        xp_a    <= hold_h;
        xp_b    <= row_h;
        lq_a    <= hold_l;
        lq_b    <= row_l;
        xp_vld  <= 1'b1;
        xp_is_l <= 1'b0;
        l_pend  <= 1'b1;
      end else if (l_pend) begin
        xp_a    <= lq_a;
        xp_b    <= lq_b;
        xp_vld  <= 1'b1;
        xp_is_l <= 1'b1;
        l_pend  <= 1'b0;
      end else begin
        xp_vld  <= 1'b0;
      end
    end
  end

  // rearrange side: (HL,HH) latched, (LL,LH) completes the group
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cph    <= 1'b0;
      lat_hl <= '0;
      lat_hh <= '0;
      sb_vld <= 1'b0;
      sb_ll  <= '0;
      sb_lh  <= '0;
      sb_hl  <= '0;
      sb_hh  <= '0;
    end else begin
      if (col_vld) begin
        cph <= !col_close;
        if (!col_close) begin
          lat_hl <= col_x;
          lat_hh <= col_y;
        end
      end
      if (col_close) begin
        sb_ll  <= col_x;
        sb_lh  <= col_y;
        sb_hl  <= lat_hl;
        sb_hh  <= lat_hh;
        sb_vld <= 1'b1;
      end else begin
        sb_vld <= 1'b0;
      end
    end
  end

  p_h_needs_row_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (xp_vld && !xp_is_l) |-> $past(row_vld));
  p_l_follows_h_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (xp_vld && !xp_is_l) |=> (xp_vld && xp_is_l));
  p_grp_needs_col_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sb_vld |-> $past(col_vld));
  p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sb_vld |=> !sb_vld);
  p_xp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !xp_vld |-> ($stable(xp_a) && $stable(xp_b)));
  p_sb_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sb_vld |-> ($stable(sb_ll) && $stable(sb_lh) && $stable(sb_hl) && $stable(sb_hh)));
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!col_vld) |=> !sb_vld);
endmodule

// File: tb/subband_xpose_rearr_tb_top.sv
module subband_xpose_rearr_tb_top;
  localparam int W = 15;
  localparam int NPU = 2;
  localparam int BW = W * NPU;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic row_vld = 1'b0, row_sos = 1'b0, col_vld = 1'b0, col_sos = 1'b0;
  logic [BW-1:0] row_h = '0, row_l = '0, col_x = '0, col_y = '0;
  logic xp_vld, xp_is_l, sb_vld;
  logic [BW-1:0] xp_a, xp_b, sb_ll, sb_lh, sb_hl, sb_hh;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  subband_xpose_rearr #(.W(W), .NPU(NPU)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .row_vld(row_vld), .row_sos(row_sos), .row_h(row_h), .row_l(row_l),
    .xp_vld(xp_vld), .xp_is_l(xp_is_l), .xp_a(xp_a), .xp_b(xp_b),
    .col_vld(col_vld), .col_sos(col_sos), .col_x(col_x), .col_y(col_y),
    .sb_vld(sb_vld), .sb_ll(sb_ll), .sb_lh(sb_lh), .sb_hl(sb_hl), .sb_hh(sb_hh));

  function automatic logic [W-1:0] pat(int k, int lane, int sel);
    if (k == 0) return (lane == 0) ? {W{1'b1}} : {1'b1, {(W-1){1'b0}}};
    return W'(k * 1237 + lane * 311 + sel * 97 + 1);
  endfunction

  function automatic logic [BW-1:0] pk(int k, int sel);
    return {pat(k, 1, sel), pat(k, 0, sel)};
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; row_vld = 0; col_vld = 0; row_sos = 0; col_sos = 0;
    step(); step();
    rst_n = 1'b1;
  endtask

  initial begin
    step(); do_reset(); step();
    // R1 reset state
    check("R1 xp_vld", 64'(xp_vld), 0);
    check("R1 sb_vld", 64'(sb_vld), 0);
    check("R1 xp data", 64'({xp_a, xp_b}), 0);
    check("R1 sb data", 64'({sb_ll, sb_hh}), 0);

    // transpose sweep (R2, R3, R7, R9, R10)
    for (int k = 0; k < 40; k++) begin
      row_vld = 1; row_sos = (k == 0); row_h = pk(k, 0); row_l = pk(k, 1);
      step();
      check("R2 open beat no valid", 64'(xp_vld), 0);
      row_sos = 0;
      for (int g = 0; g < k % 3; g++) begin
        row_vld = 0; row_h = pk(k, 7); row_l = pk(k, 8); step();
        check("R9 idle row no valid", 64'(xp_vld), 0);
      end
      row_vld = 1; row_h = pk(k, 2); row_l = pk(k, 3);
      step();
      check("R2 H valid", 64'({xp_vld, xp_is_l}), 64'b10);
      check("R2 R10 H first", 64'(xp_a), 64'(pk(k, 0)));
      check("R2 R10 H second", 64'(xp_b), 64'(pk(k, 2)));
      row_vld = 0;
      step();
      check("R3 L valid", 64'({xp_vld, xp_is_l}), 64'b11);
      check("R3 L first", 64'(xp_a), 64'(pk(k, 1)));
      check("R3 L second", 64'(xp_b), 64'(pk(k, 3)));
      step();
      check("R7 xp idle", 64'(xp_vld), 0);
      check("R7 xp hold", 64'({xp_a, xp_b}), 64'({pk(k, 1), pk(k, 3)}));
    end

    // R4 row strip realign
    row_vld = 1; row_sos = 0; row_h = pk(50, 0); row_l = pk(50, 1); step();
    row_sos = 1; row_h = pk(51, 0); row_l = pk(51, 1); step();
    check("R4 sos beat opens pair", 64'(xp_vld), 0);
    row_sos = 0; row_h = pk(52, 0); row_l = pk(52, 1); step();
    check("R4 H after realign", 64'({xp_a, xp_b}), 64'({pk(51, 0), pk(52, 0)}));
    row_vld = 0; step();
    check("R4 L after realign", 64'({xp_a, xp_b}), 64'({pk(51, 1), pk(52, 1)}));

    // rearrange sweep (R5, R7, R9, R10)
    for (int k = 0; k < 40; k++) begin
      col_vld = 1; col_sos = (k == 0); col_x = pk(k, 4); col_y = pk(k, 5);
      step();
      check("R5 HL/HH beat no valid", 64'(sb_vld), 0);
      col_sos = 0;
      for (int g = 0; g < k % 3; g++) begin
        col_vld = 0; col_x = pk(k, 9); col_y = pk(k, 10); step();
        check("R9 idle col no valid", 64'(sb_vld), 0);
      end
      col_vld = 1; col_x = pk(k, 6); col_y = pk(k, 11);
      step();
      check("R5 group valid", 64'(sb_vld), 1);
      check("R5 R10 LL", 64'(sb_ll), 64'(pk(k, 6)));
      check("R5 R10 LH", 64'(sb_lh), 64'(pk(k, 11)));
      check("R5 R10 HL", 64'(sb_hl), 64'(pk(k, 4)));
      check("R5 R10 HH", 64'(sb_hh), 64'(pk(k, 5)));
      col_vld = 0; step();
      check("R7 single pulse", 64'(sb_vld), 0);
      check("R7 sb hold", 64'({sb_ll, sb_hl}), 64'({pk(k, 6), pk(k, 4)}));
    end

    // R6 column strip realign
    col_vld = 1; col_x = pk(60, 4); col_y = pk(60, 5); step();
    col_sos = 1; col_x = pk(61, 4); col_y = pk(61, 5); step();
    check("R6 sos beat opens pair", 64'(sb_vld), 0);
    col_sos = 0; col_x = pk(62, 6); col_y = pk(62, 11); step();
    check("R6 HL after realign", 64'({sb_hl, sb_hh}), 64'({pk(61, 4), pk(61, 5)}));
    check("R6 LL after realign", 64'({sb_ll, sb_lh}), 64'({pk(62, 6), pk(62, 11)}));
    col_vld = 0; step();

    // R8 partial group dropped by reset
    col_vld = 1; col_x = pk(70, 4); col_y = pk(70, 5);
    row_vld = 1; row_h = pk(70, 0); row_l = pk(70, 1); step();
    do_reset();
    col_vld = 1; col_x = pk(71, 4); col_y = pk(71, 5);
    row_vld = 1; row_h = pk(71, 0); row_l = pk(71, 1); step();
    check("R8 no sb valid after reset", 64'(sb_vld), 0);
    check("R8 no xp valid after reset", 64'(xp_vld), 0);
    check("R8 sb data cleared", 64'(sb_ll), 0);
    col_x = pk(72, 6); col_y = pk(72, 11); row_h = pk(72, 0); step();
    check("R8 fresh group HL", 64'(sb_hl), 64'(pk(71, 4)));
    check("R8 fresh group LL", 64'(sb_ll), 64'(pk(72, 6)));
    check("R8 fresh H pair", 64'({xp_a, xp_b}), 64'({pk(71, 0), pk(72, 0)}));
    col_vld = 0; row_vld = 0; step();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule